// File: doc/BRIEF.md
# Multicast hash address filter

This block sits on the receive side of an Ethernet MAC and decides, frame by frame, whether the destination address of an incoming frame should be accepted. The 48 destination bits are presented serially, one per valid cycle. A reflected CRC-32 is computed over them as they arrive. At the last bit, the top six CRC bits index a 64-bit hash table. The frame is accepted on an exact match with the programmed station address, on the broadcast address, on a set hash bit for group addresses, or unconditionally in promiscuous mode.

A small byte-wide write port holds a control register, six station-address bytes and eight hash-table bytes. Station and table writes only land while the control register's change-enable bit is set. One cycle after the last address bit, the block raises a single-cycle decision strobe. The accept flag and the computed hash index travel with that strobe.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, the decision strobe, the accept flag and the index output are 0, and the control, station and table registers hold 0. An all-zero unicast destination therefore matches the reset station address.
- R2: The control register is at write address 0. Bit 0 is the change-enable and bit 1 is promiscuous mode. Writes to it always take effect.
- R3: Station byte i (i = 0..5, byte 0 is the first byte received) is at address 2+i. Hash-table byte j (j = 0..7) is at address 8+j. A write to any of these addresses is ignored while the change-enable bit is 0.
- R4: A frame's first bit is flagged by the start-of-frame input. Exactly 48 valid bits form the address: byte 0 first, each byte least significant bit first, so received bit k is address bit k. Valid bits outside a frame are ignored. A new start-of-frame abandons a partial frame.
- R5: The CRC starts at all ones. For each bit, if the CRC LSB XOR the data bit is 1, the CRC shifts right and is XORed with 0xEDB88320; otherwise it only shifts right. The hash index is CRC bits 31:26 after all 48 bits, and it is presented on the index output with the strobe.
- R6: Index bits 5:4 select one of four 16-bit table words, and bits 3:0 select the bit within that word. Word w consists of table byte 2w (low half) and byte 2w+1 (high half), so the index equals the table bit number 8j+b of byte j, bit b.
- R7: When address bit 0 (the group bit) is 0 and promiscuous mode is off, the frame is accepted only if the address equals the station address.
- R8: A group address is accepted when the table bit selected by its index is 1.
- R9: The all-ones broadcast address is accepted even with an empty table.
- R10: In promiscuous mode, every frame is accepted.
- R11: The decision strobe is high for exactly one cycle, in the cycle after the last address bit is sampled.
- R12: With all eight table bytes written as 0xFF, every group address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register write address |
| cfg_data_i | input | 8 | Register write data |
| rx_valid_i | input | 1 | Address bit valid |
| rx_sof_i | input | 1 | First address bit of a frame |
| rx_bit_i | input | 1 | Serial address bit |
| dec_valid_o | output | 1 | Single-cycle decision strobe |
| accept_o | output | 1 | Frame accepted, valid with the strobe |
| hash_idx_o | output | 6 | Hash index of the frame, valid with the strobe |

## Verification
The hardest case to reach from the ports is showing that every one of the 64 index values reaches the right table bit, because the index is a scrambled function of the address. The bench handles this by sweeping a single set table bit across all 64 positions. For each position, it sends a batch of group addresses and computes each address's index with its own CRC model, so that both the index and the accept flag can be predicted. Locked writes are covered by writing while change-enable is clear and observing that the decisions for the same addresses do not change. A truncated frame followed by a fresh start-of-frame checks the restart behaviour.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam int          STA_BASE = 2;
endpackage

// File: rtl/mhf_cfg_regs.sv
module mhf_cfg_regs #(
  parameter int NB_STA = 6,
  parameter int NB_TBL = 8,
  parameter int AW     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [7:0]            data_i,
  output logic                  promisc_o,
  output logic [8*NB_STA-1:0]   sta_o,
  output logic [8*NB_TBL-1:0]   tbl_o
);
  localparam int TBL_BASE = mhf_pkg::STA_BASE + NB_STA;

  logic chg_en_q, promisc_q;
  logic [8*NB_STA-1:0] sta_q;
  logic [8*NB_TBL-1:0] tbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_en_q  <= 1'b0;
      promisc_q <= 1'b0;
    end else if (we_i && addr_i == '0) begin
      chg_en_q  <= data_i[0];
      promisc_q <= data_i[1];
    end
  end

  for (genvar i = 0; i < NB_STA; i++) begin : g_sta
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sta_q[8*i +: 8] <= '0;
      else if (we_i && chg_en_q && addr_i == AW'(mhf_pkg::STA_BASE + i))
        sta_q[8*i +: 8] <= data_i;
    end
  end

  for (genvar j = 0; j < NB_TBL; j++) begin : g_tbl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl_q[8*j +: 8] <= '0;
      else if (we_i && chg_en_q && addr_i == AW'(TBL_BASE + j))
        tbl_q[8*j +: 8] <= data_i;
    end
  end

  assign promisc_o = promisc_q;
  assign sta_o     = sta_q;
  assign tbl_o     = tbl_q;

  assert_locked_sta_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chg_en_q) |=> $stable(sta_q));
  assert_locked_tbl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chg_en_q) |=> $stable(tbl_q));
endmodule

// File: rtl/mhf_crc_serial.sv
module mhf_crc_serial #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    POLY = 32'hEDB88320
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_nxt_o
);
  logic [W-1:0] crc_q, crc_in;

  assign crc_in    = start_i ? '1 : crc_q;
  assign crc_nxt_o = (crc_in[0] ^ bit_i) ? ((crc_in >> 1) ^ POLY) : (crc_in >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (step_i) crc_q <= crc_nxt_o;
  end

  // preset to ones, then a matching 1 bit only shifts
  assert_preset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && step_i && bit_i) |=> (crc_q == {1'b0, {(W-1){1'b1}}}));
endmodule

// File: rtl/mhf_addr_shift.sv
module mhf_addr_shift #(
  parameter int NBITS = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             bit_i,
  output logic             start_o,
  output logic             step_o,
  output logic             last_o,
  output logic [NBITS-1:0] addr_o
);
  localparam int CW = $clog2(NBITS + 1);

  logic [CW-1:0]    cnt_q, pos;
  logic [NBITS-1:0] addr_q;

  assign pos     = sof_i ? '0 : cnt_q;
  assign start_o = valid_i && sof_i;
  assign step_o  = valid_i && (sof_i || cnt_q != CW'(NBITS));
  assign last_o  = step_o && pos == CW'(NBITS - 1);
  assign addr_o  = {bit_i, addr_q[NBITS-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(NBITS);
      addr_q <= '0;
    end else if (step_o) begin
      cnt_q       <= pos + 1'b1;
      addr_q[pos] <= bit_i;
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NBITS));
  assert_idle_after_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (cnt_q == CW'(NBITS)));
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 6,
  parameter int CFG_AW     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [7:0]       cfg_data_i,
  input  logic             rx_valid_i,
  input  logic             rx_sof_i,
  input  logic             rx_bit_i,
  output logic             dec_valid_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] hash_idx_o
);
  import mhf_pkg::*;

  localparam int NBITS     = 8 * ADDR_BYTES;
  localparam int TBL_BITS  = 1 << IDX_W;
  localparam int TBL_BYTES = TBL_BITS / 8;

  logic                 promisc;
  logic [NBITS-1:0]     sta, addr_full;
  logic [TBL_BITS-1:0]  tbl;
  logic                 start, step, last;
  logic [CRC_W-1:0]     crc_nxt;
  logic [IDX_W-1:0]     idx;
  logic                 sta_hit, bcast, acc_d;
  logic                 dec_q, acc_q;
  logic [IDX_W-1:0]     idx_q;

  mhf_cfg_regs #(.NB_STA(ADDR_BYTES), .NB_TBL(TBL_BYTES), .AW(CFG_AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .data_i(cfg_data_i),
    .promisc_o(promisc), .sta_o(sta), .tbl_o(tbl)
  );

  mhf_addr_shift #(.NBITS(NBITS)) u_shift (
    .clk_i, .rst_ni,
    .valid_i(rx_valid_i), .sof_i(rx_sof_i), .bit_i(rx_bit_i),
    .start_o(start), .step_o(step), .last_o(last), .addr_o(addr_full)
  );

  mhf_crc_serial #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk_i, .rst_ni,
    .start_i(start), .step_i(step), .bit_i(rx_bit_i), .crc_nxt_o(crc_nxt)
  );

  assign idx     = crc_nxt[CRC_W-1 -: IDX_W];
  assign sta_hit = addr_full == sta;
  assign bcast   = &addr_full;
  assign acc_d   = promisc || sta_hit || (addr_full[0] && (bcast || tbl[idx]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= 1'b0;
      acc_q <= 1'b0;
      idx_q <= '0;
    end else begin
      dec_q <= last;
      if (last) begin
        acc_q <= acc_d;
        idx_q <= idx;
      end
    end
  end

  assign dec_valid_o = dec_q;
  assign accept_o    = acc_q;
  assign hash_idx_o  = idx_q;

  assert_single_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);
  assert_promisc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && promisc) |=> (dec_valid_o && accept_o));
  assert_bcast_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && bcast) |=> accept_o);
  assert_unicast_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !promisc && !addr_full[0] && !sta_hit) |=> !accept_o);
endmodule

// File: tb/mcast_hash_filter_bench.sv
`timescale 1ns/1ps
module mcast_hash_filter_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_bit = 1'b0;
  logic dec_valid, accept;
  logic [5:0] hash_idx;

  int checks = 0, errors = 0, pulses = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  mcast_hash_filter u_mcast_hash_filter (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_bit_i(rx_bit),
    .dec_valid_o(dec_valid), .accept_o(accept), .hash_idx_o(hash_idx)
  );

  always @(negedge clk) if (dec_valid) pulses++;

  localparam logic [47:0] STA = 48'h5544_3322_1102;

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++)
      c = (c[0] ^ a[k]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c[31:26];
  endfunction

  function automatic logic [47:0] mc_addr(input int n);
    logic [47:0] a;
    a = {16'(n * 977 + 13), 32'(n * 32'h2545F491 + 32'h1234567)};
    a[0] = 1'b1;
    if (&a) a[47] = 1'b0;
    return a;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_sta(input logic [47:0] s);
    for (int i = 0; i < 6; i++) wr(4'(2 + i), s[8*i +: 8]);
  endtask

  task automatic set_tbl(input logic [63:0] t);
    for (int j = 0; j < 8; j++) wr(4'(8 + j), t[8*j +: 8]);
  endtask

  // drives a frame, samples the strobe one cycle after the last bit
  task automatic send(input logic [47:0] a, output logic v, output logic acc, output logic [5:0] idx);
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_bit = a[k]; rx_sof = (k == 0);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_bit = 1'b0;
    v = dec_valid; acc = accept; idx = hash_idx;
    @(negedge clk);
    chk("R11 strobe drops", 64'(dec_valid), 64'd0);
  endtask

  task automatic frame_chk(input string req, input logic [47:0] a, input logic exp_acc);
    logic v, acc;
    logic [5:0] idx;
    send(a, v, acc, idx);
    chk({req, " strobe"}, 64'(v), 64'd1);
    chk({req, " accept"}, 64'(acc), 64'(exp_acc));
    chk({req, " index"}, 64'(idx), 64'(ref_idx(a)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic v, acc;
    logic [5:0] idx;
    int p0;
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", 64'(dec_valid), 64'd0);
    chk("R1 accept in reset", 64'(accept), 64'd0);
    chk("R1 index in reset", 64'(hash_idx), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    frame_chk("R1 reset station zero", 48'h0, 1'b1);
    frame_chk("R1 reset table empty", mc_addr(7), 1'b0);

    wr(4'h0, 8'h01);
    set_sta(STA);
    frame_chk("R7 station match", STA, 1'b1);
    frame_chk("R7 unicast mismatch", STA ^ 48'h0100, 1'b0);
    set_tbl('1);
    frame_chk("R7 mismatch with full table", STA ^ 48'h0100_0000, 1'b0);
    for (int n = 0; n < 20; n++) frame_chk("R12 full table", mc_addr(1000 + n), 1'b1);

    // single-bit table sweep over every index position
    for (int tb = 0; tb < 64; tb++) begin
      set_tbl(64'd1 << tb);
      for (int j = 0; j < 6; j++) begin
        logic [47:0] a;
        a = mc_addr(tb * 6 + j);
        frame_chk("R6 R8 single bit", a, ref_idx(a) == 6'(tb));
      end
    end

    set_tbl('0);
    frame_chk("R9 broadcast", '1, 1'b1);
    frame_chk("R8 empty table rejects", mc_addr(3), 1'b0);

    // locked writes
    wr(4'h0, 8'h00);
    set_tbl('1);
    frame_chk("R3 table locked", mc_addr(3), 1'b0);
    wr(4'h2, 8'h04);
    frame_chk("R3 station locked old", STA, 1'b1);
    frame_chk("R3 station locked new", {STA[47:8], 8'h04}, 1'b0);

    wr(4'h0, 8'h02);
    frame_chk("R10 promisc unicast", STA ^ 48'h0100, 1'b1);
    frame_chk("R10 promisc group", mc_addr(9), 1'b1);
    frame_chk("R2 promisc with chg off", 48'h0, 1'b1);
    wr(4'h0, 8'h00);
    frame_chk("R2 promisc cleared", STA ^ 48'h0100, 1'b0);

    // partial frame then restart
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_bit = k[0]; rx_sof = (k == 0);
    end
    frame_chk("R4 restart on sof", STA, 1'b1);

    // stray bits without sof while idle
    @(negedge clk); #1;
    p0 = pulses;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_bit = 1'b1; rx_sof = 1'b0;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk); #1;
    chk("R4 stray bits ignored", 64'(pulses - p0), 64'd0);
    frame_chk("R4 frame after stray bits", STA, 1'b1);

    // byte order: station byte 5 change matters
    send(STA ^ 48'h8000_0000_0000, v, acc, idx);
    chk("R4 last byte significant", 64'(acc), 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule